// File: doc/BRIEF.md
# Converter Result Serial Port

This block is the slave end of a three-wire serial link on an integrating data converter. A host processor drives a level-sensitive direction select and a serial clock. With the select high the port sends a result frame: three status bits (conversion done, out of range, sign) followed by the magnitude word, most significant bit first. With the select low the port receives a load value from the host's data line and hands it to the converter core as a latched parallel word.

All pins are brought into the system clock domain through two flip-flops. Edges of the serial clock and of the select are detected from the synchronised samples. When the select rises, the core's flags and magnitude are copied into a shadow shift register. A conversion that finishes while a frame is being read therefore cannot corrupt that frame. The done bit appears on the output as soon as the copy is made, so a host can poll for a new result without clocking. A received load value is committed only if the host clocked in exactly one magnitude-width of bits.

Top module: `cnv_serial_port`

## Requirements
- R1: After reset, `sdo_pin` is low and `load_o` is all zeros.
- R2: When the synchronised select rises, the port copies `eoc_i` into the shadow frame and drives it on `sdo_pin` without any serial clock edge.
- R3: In read mode, each falling serial clock edge moves the output to the next frame bit. The frame is 3+MAG_W bits long: bit 0 is `eoc_i`, bit 1 is `ovr_i`, bit 2 is `pol_i`, and bits 3 to 3+MAG_W-1 are `mag_i` from bit MAG_W-1 down to bit 0.
- R4: After the last magnitude bit, every further falling edge leaves `sdo_pin` low until the select goes low.
- R5: Changes on `eoc_i`, `ovr_i`, `pol_i` or `mag_i` after the select has risen do not change the frame being read.
- R6: While the select is low, `sdo_pin` is low.
- R7: In write mode, `sdi_pin` is sampled on each rising serial clock edge, most significant bit first. When the select returns high after exactly MAG_W such edges, `load_o` takes the received word.
- R8: If fewer or more than MAG_W bits were received in the write phase, the select's rise leaves `load_o` unchanged.
- R9: `load_o` changes only when the select rises. Serial clock activity in read mode does not touch it.
- R10: If the select rises in the same system cycle as a serial clock fall, the frame load wins. `sdo_pin` shows `eoc_i`, and the next fall shows `ovr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_pin | input | 1 | Serial clock from the host (asynchronous) |
| rw_pin | input | 1 | Direction select: high = read result, low = write load value |
| sdi_pin | input | 1 | Serial data from the host |
| eoc_i | input | 1 | Conversion done flag from the core |
| ovr_i | input | 1 | Out-of-range flag from the core |
| pol_i | input | 1 | Sign flag from the core |
| mag_i | input | MAG_W | Conversion magnitude from the core |
| sdo_pin | output | 1 | Serial data to the host |
| load_o | output | MAG_W | Latched load value for the core |

## Verification
The frame capture on a rising select and the shift on a falling serial clock can land in the same system cycle. A directed scenario provokes this by leaving the serial clock high in write mode, then lowering it at the same instant the select is raised. Both pins pass through identical synchroniser stages, so the two edges reach the logic together. The case is judged correct when the output first shows the done flag and only the next fall brings the out-of-range flag.

// File: rtl/csp_pkg.sv
package csp_pkg;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;

  function automatic edge_t edge_of(input logic now_v, input logic prev_v);
    edge_t e;
    e.rise = now_v & ~prev_v;
    e.fall = ~now_v & prev_v;
    return e;
  endfunction
endpackage

// File: rtl/csp_sync.sv
module csp_sync #(
  parameter int W      = 3,
  parameter int STAGES = csp_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] stg [STAGES+1];

  assign stg[0] = pin_i;

  genvar g;
  generate
    for (g = 1; g <= STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= '0;
        else     stg[g] <= stg[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_o <= '0;
    else     prev_o <= stg[STAGES];
  end

  assign sync_o = stg[STAGES];
endmodule

// File: rtl/csp_tx.sv
module csp_tx #(
  parameter int MAG_W = 17,
  localparam int FRAME_W = MAG_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic             rd_mode_i,
  input  logic             eoc_i,
  input  logic             ovr_i,
  input  logic             pol_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic             sdo_o
);
  logic [FRAME_W-1:0] shadow_q;
  logic               active_q;

  function automatic logic [FRAME_W-1:0] pack_frame(
    input logic e, input logic o, input logic p, input logic [MAG_W-1:0] m);
    return {e, o, p, m};
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_q <= 1'b0;
    end else if (load_i) begin
      shadow_q <= pack_frame(eoc_i, ovr_i, pol_i, mag_i);
      active_q <= 1'b1;
    end else if (!rd_mode_i) begin
      active_q <= 1'b0;
    end else if (shift_i) begin
      shadow_q <= {shadow_q[FRAME_W-2:0], 1'b0};
    end
  end

  assign sdo_o = active_q & rd_mode_i & shadow_q[FRAME_W-1];
endmodule

// File: rtl/csp_rx.sv
module csp_rx #(
  parameter int MAG_W = 17,
  localparam int CW = $clog2(MAG_W + 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             shift_i,
  input  logic             bit_i,
  input  logic             commit_i,
  output logic [MAG_W-1:0] load_o,
  output logic             commit_o
);
  localparam logic [CW-1:0] FULL = CW'(MAG_W);
  localparam logic [CW-1:0] SAT  = CW'(MAG_W + 1);

  logic [MAG_W-1:0] rx_q;
  logic [CW-1:0]    cnt_q;

  function automatic logic count_ok(input logic [CW-1:0] c);
    return c == FULL;
  endfunction

  assign commit_o = commit_i & count_ok(cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q  <= '0;
      cnt_q <= '0;
    end else if (clear_i || commit_i) begin
      cnt_q <= '0;
    end else if (shift_i) begin
      rx_q <= {rx_q[MAG_W-2:0], bit_i};
      if (cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           load_o <= '0;
    else if (commit_o) load_o <= rx_q;
  end
endmodule

// File: rtl/cnv_serial_port.sv
module cnv_serial_port #(
  parameter int MAG_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclk_pin,
  input  logic             rw_pin,
  input  logic             sdi_pin,
  input  logic             eoc_i,
  input  logic             ovr_i,
  input  logic             pol_i,
  input  logic [MAG_W-1:0] mag_i,
  output logic             sdo_pin,
  output logic [MAG_W-1:0] load_o
);
  import csp_pkg::*;

  logic [2:0] sync_v;
  logic [2:0] prev_v;
  edge_t      sclk_e;
  edge_t      rw_e;
  logic       sclk_rise, sclk_fall, rw_rise, rw_fall, rw_s, sdi_s;
  logic       wr_shift, load_evt;

  csp_sync #(.W(3)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .pin_i  ({sdi_pin, rw_pin, sclk_pin}),
    .sync_o (sync_v),
    .prev_o (prev_v)
  );

  assign sclk_e    = edge_of(sync_v[0], prev_v[0]);
  assign rw_e      = edge_of(sync_v[1], prev_v[1]);
  assign sclk_rise = sclk_e.rise;
  assign sclk_fall = sclk_e.fall;
  assign rw_rise   = rw_e.rise;
  assign rw_fall   = rw_e.fall;
  assign rw_s      = sync_v[1];
  assign sdi_s     = sync_v[2];
  assign wr_shift  = sclk_rise & ~rw_s;

  csp_tx #(.MAG_W(MAG_W)) u_tx (
    .clk       (clk),
    .rst       (rst),
    .load_i    (rw_rise),
    .shift_i   (sclk_fall),
    .rd_mode_i (rw_s),
    .eoc_i     (eoc_i),
    .ovr_i     (ovr_i),
    .pol_i     (pol_i),
    .mag_i     (mag_i),
    .sdo_o     (sdo_pin)
  );

  csp_rx #(.MAG_W(MAG_W)) u_rx (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (rw_fall),
    .shift_i  (wr_shift),
    .bit_i    (sdi_s),
    .commit_i (rw_rise),
    .load_o   (load_o),
    .commit_o (load_evt)
  );
endmodule

// File: rtl/csp_chk.sv
module csp_chk #(
  parameter int MAG_W = 17
) (
  input logic             clk,
  input logic             rst,
  input logic             sdo_pin,
  input logic [MAG_W-1:0] load_o,
  input logic             eoc_i,
  input logic             rw_s,
  input logic             rw_rise,
  input logic             rw_fall,
  input logic             sclk_rise,
  input logic             sclk_fall
);
  localparam int FRAME_W = MAG_W + 3;
  localparam int OW = $clog2(FRAME_W + 2);
  localparam int WW = $clog2(MAG_W + 2);

  logic [OW-1:0] out_cnt;
  logic [WW-1:0] in_cnt;

  always_ff @(posedge clk) begin
    if (rst || rw_rise) out_cnt <= '0;
    else if (rw_s && sclk_fall && out_cnt != OW'(FRAME_W + 1)) out_cnt <= out_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || rw_fall || rw_rise) in_cnt <= '0;
    else if (!rw_s && sclk_rise && in_cnt != WW'(MAG_W + 1)) in_cnt <= in_cnt + 1'b1;
  end

  p_eoc_on_select_r2: assert property (@(posedge clk) disable iff (rst)
    rw_rise |=> (sdo_pin == $past(eoc_i)));

  p_tail_low_r4: assert property (@(posedge clk) disable iff (rst)
    (rw_s && !rw_rise && out_cnt >= OW'(FRAME_W)) |-> !sdo_pin);

  p_write_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !rw_s |-> !sdo_pin);

  p_load_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !rw_rise |=> $stable(load_o));

  p_load_count_r8: assert property (@(posedge clk) disable iff (rst)
    (rw_rise && in_cnt != WW'(MAG_W)) |=> $stable(load_o));
endmodule

bind cnv_serial_port csp_chk #(.MAG_W(MAG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sdo_pin   (sdo_pin),
  .load_o    (load_o),
  .eoc_i     (eoc_i),
  .rw_s      (rw_s),
  .rw_rise   (rw_rise),
  .rw_fall   (rw_fall),
  .sclk_rise (sclk_rise),
  .sclk_fall (sclk_fall)
);

// File: tb/cnv_serial_port_tb.sv
module cnv_serial_port_tb_top;
  localparam int MAG_W   = 17;
  localparam int FRAME_W = MAG_W + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_pin = 1'b0, rw_pin = 1'b0, sdi_pin = 1'b0;
  logic eoc_i = 1'b0, ovr_i = 1'b0, pol_i = 1'b0;
  logic [MAG_W-1:0] mag_i = '0;
  logic sdo_pin;
  logic [MAG_W-1:0] load_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cnv_serial_port #(.MAG_W(MAG_W)) dut_i (
    .clk(clk), .rst(rst), .sclk_pin(sclk_pin), .rw_pin(rw_pin), .sdi_pin(sdi_pin),
    .eoc_i(eoc_i), .ovr_i(ovr_i), .pol_i(pol_i), .mag_i(mag_i),
    .sdo_pin(sdo_pin), .load_o(load_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic fall_edge();
    sclk_pin = 1'b1; settle();
    sclk_pin = 1'b0; settle();
  endtask

  function automatic logic frame_bit(input logic e, input logic o, input logic p,
                                     input logic [MAG_W-1:0] m, input int k);
    if (k == 0) return e;
    if (k == 1) return o;
    if (k == 2) return p;
    if (k < FRAME_W) return m[MAG_W-1-(k-3)];
    return 1'b0;
  endfunction

  task automatic t_reset();
    check("R1 sdo after reset", 32'(sdo_pin), 0);
    check("R1 load after reset", 32'(load_o), 0);
  endtask

  // R2 R3 R4 R5 R6 R9: full read frame, optional core change mid-frame
  task automatic t_read(input logic e, input logic o, input logic p,
                        input logic [MAG_W-1:0] m, input bit disturb);
    logic [MAG_W-1:0] keep_load;
    int bad = 0;
    keep_load = load_o;
    rw_pin = 1'b0; settle();
    eoc_i = e; ovr_i = o; pol_i = p; mag_i = m;
    rw_pin = 1'b1; settle();
    check("R2 done bit polled", 32'(sdo_pin), 32'(e));
    if (disturb) begin
      eoc_i = ~e; ovr_i = ~o; pol_i = ~p; mag_i = ~m;
    end
    for (int k = 1; k < FRAME_W + 3; k++) begin
      sdi_pin = k[0];
      fall_edge();
      if (sdo_pin !== frame_bit(e, o, p, m, k)) bad++;
    end
    check(disturb ? "R5 frame frozen" : "R3 frame order", 32'(bad), 0);
    check("R4 tail low", 32'(sdo_pin), 0);
    check("R9 load untouched by read clocks", 32'(load_o), 32'(keep_load));
    rw_pin = 1'b0; settle();
    check("R6 write mode quiet", 32'(sdo_pin), 0);
  endtask

  // R7 R8: write n bits of v, expect load afterwards
  task automatic t_write(input logic [31:0] v, input int n, input logic [MAG_W-1:0] expv,
                         input string req);
    rw_pin = 1'b0; sclk_pin = 1'b0; settle();
    for (int k = n - 1; k >= 0; k--) begin
      sdi_pin = v[k];
      sclk_pin = 1'b1; settle();
      check("R6 quiet while writing", 32'(sdo_pin), 0);
      sclk_pin = 1'b0; settle();
    end
    rw_pin = 1'b1; settle();
    check(req, 32'(load_o), 32'(expv));
  endtask

  // R10: select rise and serial clock fall in one cycle
  task automatic t_coincide();
    rw_pin = 1'b0; sclk_pin = 1'b1; settle();
    eoc_i = 1'b1; ovr_i = 1'b0; pol_i = 1'b1; mag_i = 17'h10001;
    @(negedge clk);
    rw_pin = 1'b1; sclk_pin = 1'b0;
    settle();
    check("R10 load wins, done bit shown", 32'(sdo_pin), 1);
    fall_edge();
    check("R10 next fall gives overrange", 32'(sdo_pin), 0);
    fall_edge();
    check("R10 then polarity", 32'(sdo_pin), 1);
    rw_pin = 1'b0; settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    t_reset();
    t_read(1'b1, 1'b0, 1'b1, 17'h1A5C3, 1'b0);
    t_read(1'b0, 1'b1, 1'b0, 17'h0F0F1, 1'b0);
    t_read(1'b1, 1'b1, 1'b0, 17'h12345, 1'b1);
    t_write(32'h15A5A, MAG_W, 17'h15A5A, "R7 exact count commits");
    t_write(32'h0BEEF, MAG_W - 1, 17'h15A5A, "R8 short write ignored");
    t_write(32'h3FFFF, MAG_W + 1, 17'h15A5A, "R8 long write ignored");
    t_write(32'h00F0F, MAG_W, 17'h00F0F, "R7 second commit");
    t_read(1'b0, 1'b0, 1'b1, 17'h1FFFF, 1'b0);
    t_coincide();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule